// File: doc/BRIEF.md
# ISA Peripheral I/O Window Decoder

This block sits between the ISA-style host bus and the register file of a peripheral. It watches the ten slave address lines and the address-enable line to decide whether a host I/O cycle targets the peripheral's aligned I/O window. When a cycle does, the block turns the active-low read and write strobes into internal register read and write strobes, and it steers bytes between the two bus data lanes and the internal 16-bit register word. A combinational decode drives the 16-bit I/O select indication. That decode looks only at the address and address-enable lines, and a configuration bit can switch it off so that the host splits every word access into two byte accesses.

The strobes and address-enable pass through two-flop synchronizers. A control state machine then follows each cycle through five states. `ST_IDLE` waits for a qualified strobe. `ST_RD_START` issues the one-cycle register read strobe and drives the bus. `ST_RD_HOLD` keeps driving while the read strobe stays low. `ST_WR_ACTIVE` samples address and write data while the write strobe is low. `ST_WR_PULSE` issues the one-cycle register write strobe. The transitions are: idle-to-read-start on a qualified read, idle-to-write-active on a qualified write (a read wins when both strobes are low), read-start-to-read-hold, any read state back to idle when the read strobe releases or address-enable rises, write-active-to-write-pulse when the write strobe releases, write-active-to-idle on address-enable rising, and write-pulse-to-idle always.

Top module: `isa_io_decoder`

## Requirements
- R1: A cycle targets the device only when address-enable is low and sa[9:4] equals win_base; offset sa[3:0] selects the byte, and reg_sel = sa[3:1] is the word index.
- R2: With cfg_io16 = 1, iocs16_oe is 1 exactly when R1 holds, whatever the state of the read and write strobes.
- R3: With cfg_io16 = 0, iocs16_oe stays 0 for every address and address-enable value.
- R4: A qualified low read strobe gives exactly one reg_rd pulse and holds bus_oe_lo high while the strobe stays low. bus_oe_lo falls after the strobe releases.
- R5: A qualified low write strobe gives exactly one reg_wr pulse after the strobe releases. reg_sel and data in that pulse are the values sampled while the strobe was low.
- R6: While address-enable is high, read and write strobes produce no reg_rd, no reg_wr and no bus drive.
- R7: With cfg_io16 = 0, a read drives only the low lane (bus_oe_hi = 0). bus_dout[7:0] carries reg_rdata[15:8] at an odd offset and reg_rdata[7:0] at an even offset.
- R8: With cfg_io16 = 1, a read drives both lanes with bus_dout = reg_rdata.
- R9: Write steering. With cfg_io16 = 1, an even offset gives reg_wbe = 2'b11 with reg_wdata = bus_din, and an odd offset gives reg_wbe = 2'b10 with reg_wdata[15:8] = bus_din[15:8]. With cfg_io16 = 0, an even offset gives reg_wbe = 2'b01 with reg_wdata[7:0] = bus_din[7:0], and an odd offset gives reg_wbe = 2'b10 with reg_wdata[15:8] = bus_din[7:0].
- R10: If both strobes go low together and release together, the cycle is a read: one reg_rd and no reg_wr.
- R11: After reset, reg_rd, reg_wr, bus_oe_lo and bus_oe_hi are 0.
- R12: An address outside the window gives no reg_rd, no reg_wr and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sa | input | 10 | Slave address lines |
| aen | input | 1 | Address enable; high during DMA cycles |
| ior_n | input | 1 | Active-low host I/O read strobe |
| iow_n | input | 1 | Active-low host I/O write strobe |
| win_base | input | 6 | Window number; compared with sa[9:4] |
| cfg_io16 | input | 1 | 1 allows 16-bit I/O, 0 forces byte-only |
| bus_din | input | 16 | Host data lanes, write direction |
| bus_dout | output | 16 | Read data toward the host lanes |
| bus_oe_lo | output | 1 | Drive enable for lane 7:0 |
| bus_oe_hi | output | 1 | Drive enable for lane 15:8 |
| iocs16_oe | output | 1 | Open-drain pull-down enable for the 16-bit select |
| reg_sel | output | 3 | Register word index |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wbe | output | 2 | Byte enables for the write |
| reg_wdata | output | 16 | Steered write data |
| reg_rdata | input | 16 | Register word for the selected index |

## Verification
The combinational 16-bit select decode and the strobe state machine act in the same cycle. The bench checks iocs16_oe while a read strobe is held low and the machine is driving the bus, and expects the select to follow the address alone. A read and a write can also start in the same cycle. The bench lowers and raises both strobes together and counts the strobe pulses: one read, zero writes. Full sweeps over every window offset in both width modes judge the lane steering against values computed arithmetically from the offset parity and the mode.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_HOLD,
        ST_WR_ACTIVE,
        ST_WR_PULSE
    } dec_state_t;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/isa_sync_chain.sv
module isa_sync_chain #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
    parameter int AW       = 10,
    parameter int WIN_BITS = 4,
    localparam int BW      = AW - WIN_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sa,
    input  logic          aen,
    input  logic [BW-1:0] win_base,
    input  logic          cfg_io16,
    output logic          in_win,
    output logic          iocs16_oe
);
    assign in_win    = (sa[AW-1:WIN_BITS] == win_base);
    assign iocs16_oe = cfg_io16 && !aen && in_win;

    // R2: select never asserted during a DMA (aen high) cycle
    p_iocs_no_dma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aen |-> !iocs16_oe);
endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer #(
    parameter int DW = 16,
    localparam int HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          odd,
    input  logic          rd_active,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe_lo,
    output logic          oe_hi,
    output logic [1:0]    wbe,
    output logic [DW-1:0] wdata
);
    logic narrow_odd;
    assign narrow_odd = !wide && odd;

    always_comb begin
        if (narrow_odd) dout = {rdata[DW-1:HW], rdata[DW-1:HW]};
        else            dout = rdata;
        oe_lo = rd_active;
        oe_hi = rd_active && wide;
    end

    always_comb begin
        if (narrow_odd) wdata = {din[HW-1:0], din[HW-1:0]};
        else            wdata = din;
        if (odd)        wbe = 2'b10;
        else if (wide)  wbe = 2'b11;
        else            wbe = 2'b01;
    end

    // R7: byte-only mode never drives the upper lane
    p_hi_lane_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> !oe_hi);
    // R9: at least one byte is always enabled
    p_wbe_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wbe != 2'b00);
endmodule

// File: rtl/isa_io_decoder.sv
module isa_io_decoder
    import isa_dec_pkg::*;
#(
    parameter int AW       = 10,
    parameter int WIN_BITS = 4,
    parameter int DW       = 16,
    localparam int BW      = AW - WIN_BITS,
    localparam int SW      = WIN_BITS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sa,
    input  logic          aen,
    input  logic          ior_n,
    input  logic          iow_n,
    input  logic [BW-1:0] win_base,
    input  logic          cfg_io16,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe_lo,
    output logic          bus_oe_hi,
    output logic          iocs16_oe,
    output logic [SW-1:0] reg_sel,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [1:0]    reg_wbe,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    logic [2:0]          strb_s;
    logic                aen_s, iow_s, ior_s;
    logic                in_win, qual;
    dec_state_t          state, state_nx;
    logic [WIN_BITS-1:0] cap_addr;
    logic [DW-1:0]       cap_data;
    logic                rd_active;

    isa_sync_chain #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({aen, iow_n, ior_n}),
        .q     (strb_s)
    );
    assign {aen_s, iow_s, ior_s} = strb_s;

    isa_addr_match #(.AW(AW), .WIN_BITS(WIN_BITS)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .sa        (sa),
        .aen       (aen),
        .win_base  (win_base),
        .cfg_io16  (cfg_io16),
        .in_win    (in_win),
        .iocs16_oe (iocs16_oe)
    );

    assign qual = in_win && !aen_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (qual && !ior_s)      state_nx = ST_RD_START;
                else if (qual && !iow_s) state_nx = ST_WR_ACTIVE;
            end
            ST_RD_START: begin
                if (ior_s || aen_s) state_nx = ST_IDLE;
                else                state_nx = ST_RD_HOLD;
            end
            ST_RD_HOLD: begin
                if (ior_s || aen_s) state_nx = ST_IDLE;
            end
            ST_WR_ACTIVE: begin
                if (aen_s)      state_nx = ST_IDLE;
                else if (iow_s) state_nx = ST_WR_PULSE;
            end
            ST_WR_PULSE: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (state == ST_IDLE) begin
            cap_addr <= sa[WIN_BITS-1:0];
            cap_data <= bus_din;
        end else if (state == ST_WR_ACTIVE && !iow_s) begin
            cap_addr <= sa[WIN_BITS-1:0];
            cap_data <= bus_din;
        end
    end

    always_comb begin
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        rd_active = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_RD_START:  begin reg_rd = 1'b1; rd_active = 1'b1; end
            ST_RD_HOLD:   rd_active = 1'b1;
            ST_WR_ACTIVE: ;
            ST_WR_PULSE:  reg_wr = 1'b1;
            default:      ;
        endcase
    end

    assign reg_sel = cap_addr[WIN_BITS-1:1];

    isa_lane_steer #(.DW(DW)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (cfg_io16),
        .odd       (cap_addr[0]),
        .rd_active (rd_active),
        .rdata     (reg_rdata),
        .din       (cap_data),
        .dout      (bus_dout),
        .oe_lo     (bus_oe_lo),
        .oe_hi     (bus_oe_hi),
        .wbe       (reg_wbe),
        .wdata     (reg_wdata)
    );

    // R10: read and write strobes never coincide
    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
    // R4: read strobe lasts one cycle
    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R5: write strobe lasts one cycle and follows a released write strobe
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_wr_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(iow_s));
    // R6: no bus drive while the synchronized address-enable is high
    p_oe_no_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aen_s && $past(aen_s)) |-> !bus_oe_lo);
endmodule

// File: tb/isa_io_decoder_bench.sv
module isa_io_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sa = '0;
    logic        aen = 1'b1;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic [5:0]  win_base = 6'h30;
    logic        cfg_io16 = 1'b1;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_oe_lo, bus_oe_hi, iocs16_oe;
    logic [2:0]  reg_sel;
    logic        reg_rd, reg_wr;
    logic [1:0]  reg_wbe;
    logic [15:0] reg_wdata, reg_rdata;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [2:0]  last_wsel;
    logic [1:0]  last_wbe;
    logic [15:0] last_wdata;
    bit done = 0;

    always #2 clk = ~clk;

    assign reg_rdata = {8'hA0 + {5'd0, reg_sel}, 8'h50 + {5'd0, reg_sel}};

    isa_io_decoder u_isa_io_decoder (
        .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
        .win_base(win_base), .cfg_io16(cfg_io16), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi),
        .iocs16_oe(iocs16_oe), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wbe(reg_wbe), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (reg_rd) rd_cnt++;
        if (reg_wr) begin
            wr_cnt++;
            last_wsel  = reg_sel;
            last_wbe   = reg_wbe;
            last_wdata = reg_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [9:0] a, input logic dma, input string req);
        int r0;
        logic [7:0] hi, lo;
        logic hitw;
        r0 = rd_cnt;
        hitw = (a[9:4] == win_base) && !dma;
        hi = 8'hA0 + {5'd0, a[3:1]};
        lo = 8'h50 + {5'd0, a[3:1]};
        @(negedge clk);
        sa = a; aen = dma; ior_n = 1'b0;
        cyc(6);
        // R2: select follows address while the read strobe is low
        chk({req, "/R2"}, {31'd0, iocs16_oe}, {31'd0, hitw && cfg_io16});
        chk({req, "/R4 oe_lo"}, {31'd0, bus_oe_lo}, {31'd0, hitw});
        chk({req, "/R7 oe_hi"}, {31'd0, bus_oe_hi}, {31'd0, hitw && cfg_io16});
        if (hitw && cfg_io16)
            chk({req, "/R8 data"}, {16'd0, bus_dout}, {16'd0, hi, lo});
        else if (hitw)
            chk({req, "/R7 data"}, {24'd0, bus_dout[7:0]}, {24'd0, a[0] ? hi : lo});
        ior_n = 1'b1;
        cyc(6);
        chk({req, "/R4 release"}, {31'd0, bus_oe_lo}, 32'd0);
        chk({req, "/R4 pulses"}, rd_cnt - r0, hitw ? 32'd1 : 32'd0);
        aen = 1'b1;
    endtask

    task automatic do_write(input logic [9:0] a, input logic dma, input logic [15:0] d,
                            input string req);
        int w0;
        logic hitw;
        w0 = wr_cnt;
        hitw = (a[9:4] == win_base) && !dma;
        @(negedge clk);
        sa = a; aen = dma; bus_din = d; iow_n = 1'b0;
        cyc(5);
        iow_n = 1'b1;
        cyc(6);
        chk({req, "/R5 pulses"}, wr_cnt - w0, hitw ? 32'd1 : 32'd0);
        if (hitw) begin
            chk({req, "/R5 sel"}, {29'd0, last_wsel}, {29'd0, a[3:1]});
            if (cfg_io16 && !a[0]) begin
                chk({req, "/R9 wbe"}, {30'd0, last_wbe}, 32'd3);
                chk({req, "/R9 data"}, {16'd0, last_wdata}, {16'd0, d});
            end else if (cfg_io16) begin
                chk({req, "/R9 wbe"}, {30'd0, last_wbe}, 32'd2);
                chk({req, "/R9 data"}, {24'd0, last_wdata[15:8]}, {24'd0, d[15:8]});
            end else if (a[0]) begin
                chk({req, "/R9 wbe"}, {30'd0, last_wbe}, 32'd2);
                chk({req, "/R9 data"}, {24'd0, last_wdata[15:8]}, {24'd0, d[7:0]});
            end else begin
                chk({req, "/R9 wbe"}, {30'd0, last_wbe}, 32'd1);
                chk({req, "/R9 data"}, {24'd0, last_wdata[7:0]}, {24'd0, d[7:0]});
            end
        end
        aen = 1'b1;
    endtask

    initial begin
        cyc(3);
        // R11: reset state
        chk("R11 rd", {31'd0, reg_rd}, 32'd0);
        chk("R11 wr", {31'd0, reg_wr}, 32'd0);
        chk("R11 oe", {30'd0, bus_oe_hi, bus_oe_lo}, 32'd0);
        rst_n = 1'b1;
        cyc(3);

        // R1 R2 R3: full decode sweep with strobes idle
        for (int c = 0; c < 2; c++)
            for (int e = 0; e < 2; e++)
                for (int a = 0; a < 1024; a++) begin
                    cfg_io16 = c[0]; aen = e[0]; sa = a[9:0];
                    #1;
                    chk(c[0] ? "R2 R1 decode" : "R3 decode off", {31'd0, iocs16_oe},
                        {31'd0, c[0] && !e[0] && (a[9:4] == 6'h30)});
                end
        aen = 1'b1;
        cyc(4);

        for (int c = 0; c < 2; c++) begin
            cfg_io16 = c[0];
            for (int o = 0; o < 16; o++) begin
                do_read(10'h300 + 10'(o), 1'b0, c[0] ? "R8 sweep" : "R7 sweep");
                do_write(10'h300 + 10'(o), 1'b0, 16'h1234 + 16'(o * 16'h0101),
                         "R9 sweep");
            end
        end

        // R12: outside the window
        do_read(10'h2F4, 1'b0, "R12 miss");
        do_write(10'h312, 1'b0, 16'hBEEF, "R12 miss");
        // R6: address-enable high
        do_read(10'h304, 1'b1, "R6 dma");
        do_write(10'h306, 1'b1, 16'hCAFE, "R6 dma");

        // R10: both strobes together
        begin
            int r0, w0;
            r0 = rd_cnt; w0 = wr_cnt;
            @(negedge clk);
            sa = 10'h308; aen = 1'b0; ior_n = 1'b0; iow_n = 1'b0;
            cyc(6);
            ior_n = 1'b1; iow_n = 1'b1;
            cyc(8);
            chk("R10 reads", rd_cnt - r0, 32'd1);
            chk("R10 writes", wr_cnt - w0, 32'd0);
            aen = 1'b1;
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule